// File: doc/BRIEF.md
# Host Packet Buffer Pointer Window

This block lets a host processor reach packet bytes in the buffer RAM through two registers: a pointer and a data port. The host writes the pointer with a byte offset, an area-select bit and an auto-advance enable. Each access to the data port then lands on the RAM location of that offset inside the selected packet. The block never lets the host address the RAM directly.

The area-select bit chooses which packet the offset applies to. In the transmit area, the packet is the one named in a host-written transmit packet register. The host fills this register after a successful allocation, and uses the same area later to read that packet's completion status. In the receive area, the packet is the head of the receive queue, which is the oldest received packet that the host has not yet handled. An external allocator turns the pair (packet, offset) into a physical byte address.

A small state machine sequences each access. `ST_IDLE` accepts a request and moves to one of three states:
- `ST_READ` for a read into a valid window,
- `ST_WRITE` for a write into a valid window,
- `ST_VOID` for any access to the receive area while the receive queue is empty.

Each of these three states returns unconditionally to `ST_IDLE` after one cycle. Ready is asserted in each of them.

Top module: `hbw_window`

## Requirements
- R1: After reset `dp_ready`, `dp_nvalid` and `dp_rdata` are 0, the offset `xl_off` is 0, the transmit area is selected and the transmit packet register holds 0.
- R2: A pointer write loads `ptr_wdata[OFF_W-1:0]` as the offset, bit `OFF_W` as the area select (1 = receive) and bit `OFF_W+1` as the auto-advance enable. The new offset appears on `xl_off` in the next cycle. A pointer write in the same cycle as an accepted access wins over the advance, and the access itself uses the old pointer.
- R3: With auto-advance on, an accepted byte access (`dp_wide`=0) adds 1 to the offset.
- R4: With auto-advance on, an accepted 16-bit access (`dp_wide`=1) adds 2 to the offset.
- R5: The offset wraps modulo 2^OFF_W, so 2046 plus 2 gives 0 and 2047 plus 1 gives 0.
- R6: With auto-advance off, accesses leave the offset unchanged.
- R7: In the transmit area, `xl_pkt` equals the transmit packet register. That register is loaded by `pkt_wr` and is used by accesses accepted after the load edge.
- R8: In the receive area, `xl_pkt` equals `rxq_head`. A read there returns data that was written through the transmit area at the same packet and offset.
- R9: An access to the receive area while `rxq_empty`=1 completes with `dp_ready`=1, `dp_nvalid`=1 and `dp_rdata`=0. The RAM is not enabled.
- R10: A write to the receive area while it is empty leaves the RAM unchanged.
- R11: A request accepted in `ST_IDLE` gives `dp_ready` for exactly the next cycle. A request in that ready cycle is ignored.
- R12: Byte lanes. Bit 0 of the translated byte address selects the lane: 0 is `ram_rdata[7:0]`/`ram_be`=01, and 1 is `[15:8]`/`ram_be`=10. A byte read returns the byte zero-extended. A 16-bit access uses `ram_be`=11 at word `xl_addr[AW-1:1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr | input | 1 | Pointer register write strobe |
| ptr_wdata | input | OFF_W+2 | Offset, area select, auto-advance enable |
| pkt_wr | input | 1 | Transmit packet register write strobe |
| pkt_wdata | input | PKT_W | Transmit packet number |
| dp_req | input | 1 | Data port access request |
| dp_we | input | 1 | 1 = write, 0 = read |
| dp_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| dp_wdata | input | 16 | Write data (byte access uses bits 7:0) |
| dp_rdata | output | 16 | Read data, valid with `dp_ready` |
| dp_ready | output | 1 | Access completes this cycle |
| dp_nvalid | output | 1 | Completed access hit an empty receive area |
| rxq_head | input | PKT_W | Packet number at the head of the receive queue |
| rxq_empty | input | 1 | Receive queue is empty |
| xl_pkt | output | PKT_W | Packet number sent to the allocator |
| xl_off | output | OFF_W | Current offset sent to the allocator |
| xl_addr | input | AW | Physical byte address returned by the allocator |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW-1 | RAM word address |
| ram_be | output | 2 | RAM byte enables |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, one cycle after `ram_en` |

## Verification
Byte writes with auto-advance are read back byte by byte, and 16-bit writes are read back as single bytes. This separates lane selection from the advance step of 1 versus 2. Loading the pointer near the top of the offset range exposes the wrap. Repeated reads with auto-advance off show whether the offset is stuck or drifting.

Data written through the transmit area under one packet number is then read through the receive area with a matching queue head. This separates the two packet sources behind the single select bit. Accesses with an empty queue, followed by a read once the queue is filled, show that void accesses return zero and never reach the RAM. Back-to-back requests show that the ready pulse lasts one cycle and that the second request is dropped.

// File: rtl/hbw_pkg.sv
package hbw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_VOID
    } hbw_state_e;

    localparam int unsigned DATA_W = 16;
    localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/hbw_ptr_reg.sv
module hbw_ptr_reg #(
    parameter int unsigned OFF_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [OFF_W+1:0] ld_data,
    input  logic             adv,
    input  logic             adv_wide,
    output logic [OFF_W-1:0] off,
    output logic             rx_sel,
    output logic             auto_inc
);
    localparam int unsigned SEL_BIT = OFF_W;
    localparam int unsigned INC_BIT = OFF_W + 1;

    logic [OFF_W-1:0] step;

    always_comb begin
        step = adv_wide ? OFF_W'(2) : OFF_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off      <= '0;
            rx_sel   <= 1'b0;
            auto_inc <= 1'b0;
        end else if (ld) begin
            off      <= ld_data[OFF_W-1:0];
            rx_sel   <= ld_data[SEL_BIT];
            auto_inc <= ld_data[INC_BIT];
        end else if (adv && auto_inc) begin
            off      <= off + step;
        end
    end
endmodule

// File: rtl/hbw_ctrl.sv
module hbw_ctrl
    import hbw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic we,
    input  logic tgt_void,
    output logic accept,
    output logic idle,
    output logic ready,
    output logic nvalid,
    output logic rd_phase
);
    hbw_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    if (tgt_void) begin
                        state_nx = ST_VOID;
                    end else if (we) begin
                        state_nx = ST_WRITE;
                    end else begin
                        state_nx = ST_READ;
                    end
                end
            end
            ST_READ:  state_nx = ST_IDLE;
            ST_WRITE: state_nx = ST_IDLE;
            ST_VOID:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        idle     = 1'b0;
        ready    = 1'b0;
        nvalid   = 1'b0;
        rd_phase = 1'b0;
        unique case (state)
            ST_IDLE:  idle = 1'b1;
            ST_READ:  begin ready = 1'b1; rd_phase = 1'b1; end
            ST_WRITE: ready = 1'b1;
            ST_VOID:  begin ready = 1'b1; nvalid = 1'b1; end
            default:  idle = 1'b0;
        endcase
        accept = idle && req;
    end
endmodule

// File: rtl/hbw_lane.sv
module hbw_lane
    import hbw_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              tgt_void,
    input  logic              we,
    input  logic              wide,
    input  logic [AW-1:0]     phys,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic              rd_phase,
    output logic              ram_en,
    output logic              ram_we,
    output logic [AW-2:0]     ram_addr,
    output logic [1:0]        ram_be,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [DATA_W-1:0] rdata
);
    logic lane_q;
    logic wide_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= 1'b0;
            wide_q <= 1'b0;
        end else if (accept) begin
            lane_q <= phys[0];
            wide_q <= wide;
        end
    end

    always_comb begin
        ram_en   = accept && !tgt_void;
        ram_we   = we;
        ram_addr = phys[AW-1:1];
        if (wide) begin
            ram_be    = 2'b11;
            ram_wdata = wdata;
        end else begin
            ram_be    = phys[0] ? 2'b10 : 2'b01;
            ram_wdata = {wdata[LANE_W-1:0], wdata[LANE_W-1:0]};
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_phase) begin
            if (wide_q) begin
                rdata = ram_rdata;
            end else if (lane_q) begin
                rdata = {{LANE_W{1'b0}}, ram_rdata[DATA_W-1:LANE_W]};
            end else begin
                rdata = {{LANE_W{1'b0}}, ram_rdata[LANE_W-1:0]};
            end
        end
    end
endmodule

// File: rtl/hbw_window.sv
module hbw_window
    import hbw_pkg::*;
#(
    parameter int unsigned PKT_W = 5,
    parameter int unsigned OFF_W = 11,
    parameter int unsigned AW    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_wr,
    input  logic [OFF_W+1:0]  ptr_wdata,
    input  logic              pkt_wr,
    input  logic [PKT_W-1:0]  pkt_wdata,
    input  logic              dp_req,
    input  logic              dp_we,
    input  logic              dp_wide,
    input  logic [15:0]       dp_wdata,
    output logic [15:0]       dp_rdata,
    output logic              dp_ready,
    output logic              dp_nvalid,
    input  logic [PKT_W-1:0]  rxq_head,
    input  logic              rxq_empty,
    output logic [PKT_W-1:0]  xl_pkt,
    output logic [OFF_W-1:0]  xl_off,
    input  logic [AW-1:0]     xl_addr,
    output logic              ram_en,
    output logic              ram_we,
    output logic [AW-2:0]     ram_addr,
    output logic [1:0]        ram_be,
    output logic [15:0]       ram_wdata,
    input  logic [15:0]       ram_rdata
);
    logic             rx_sel;
    logic             auto_inc;
    logic             tgt_void;
    logic             accept;
    logic             fsm_idle;
    logic             rd_phase;
    logic [PKT_W-1:0] tx_pkt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_pkt <= '0;
        end else if (pkt_wr) begin
            tx_pkt <= pkt_wdata;
        end
    end

    always_comb begin
        xl_pkt   = rx_sel ? rxq_head : tx_pkt;
        tgt_void = rx_sel && rxq_empty;
    end

    hbw_ptr_reg #(.OFF_W(OFF_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (ptr_wr),
        .ld_data  (ptr_wdata),
        .adv      (accept),
        .adv_wide (dp_wide),
        .off      (xl_off),
        .rx_sel   (rx_sel),
        .auto_inc (auto_inc)
    );

    hbw_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (dp_req),
        .we       (dp_we),
        .tgt_void (tgt_void),
        .accept   (accept),
        .idle     (fsm_idle),
        .ready    (dp_ready),
        .nvalid   (dp_nvalid),
        .rd_phase (rd_phase)
    );

    hbw_lane #(.AW(AW)) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .tgt_void  (tgt_void),
        .we        (dp_we),
        .wide      (dp_wide),
        .phys      (xl_addr),
        .wdata     (dp_wdata),
        .ram_rdata (ram_rdata),
        .rd_phase  (rd_phase),
        .ram_en    (ram_en),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_be    (ram_be),
        .ram_wdata (ram_wdata),
        .rdata     (dp_rdata)
    );
endmodule

// File: rtl/hbw_window_chk.sv
module hbw_window_chk #(
    parameter int unsigned OFF_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dp_req,
    input logic             dp_wide,
    input logic             ptr_wr,
    input logic             idle,
    input logic             auto_inc,
    input logic             tgt_void,
    input logic             dp_ready,
    input logic             dp_nvalid,
    input logic [15:0]      dp_rdata,
    input logic             ram_en,
    input logic [1:0]       ram_be,
    input logic [OFF_W-1:0] xl_off
);
    a_r11_ready_next: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_req && idle) |=> dp_ready);

    a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dp_ready |=> !dp_ready);

    a_r9_void_zero: assert property (@(posedge clk) disable iff (!rst_n)
        dp_nvalid |-> (dp_ready && dp_rdata == 16'h0000));

    a_r10_void_no_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_req && idle && tgt_void) |-> !ram_en);

    a_r12_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && !dp_wide) |-> ($countones(ram_be) == 1));

    a_r3_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_req && idle && auto_inc && !dp_wide && !ptr_wr)
        |=> (xl_off == OFF_W'($past(xl_off) + 1)));

    a_r4_wide_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_req && idle && auto_inc && dp_wide && !ptr_wr)
        |=> (xl_off == OFF_W'($past(xl_off) + 2)));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_wr && !(dp_req && idle && auto_inc)) |=> $stable(xl_off));
endmodule

bind hbw_window hbw_window_chk #(.OFF_W(OFF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dp_req    (dp_req),
    .dp_wide   (dp_wide),
    .ptr_wr    (ptr_wr),
    .idle      (fsm_idle),
    .auto_inc  (auto_inc),
    .tgt_void  (tgt_void),
    .dp_ready  (dp_ready),
    .dp_nvalid (dp_nvalid),
    .dp_rdata  (dp_rdata),
    .ram_en    (ram_en),
    .ram_be    (ram_be),
    .xl_off    (xl_off)
);

// File: tb/sim_hbw_window.sv
`timescale 1ns/1ps
module sim_hbw_window;
    localparam int PKT_W = 5;
    localparam int OFF_W = 11;
    localparam int AW    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              ptr_wr = 1'b0;
    logic [OFF_W+1:0]  ptr_wdata = '0;
    logic              pkt_wr = 1'b0;
    logic [PKT_W-1:0]  pkt_wdata = '0;
    logic              dp_req = 1'b0;
    logic              dp_we = 1'b0;
    logic              dp_wide = 1'b0;
    logic [15:0]       dp_wdata = '0;
    logic [15:0]       dp_rdata;
    logic              dp_ready;
    logic              dp_nvalid;
    logic [PKT_W-1:0]  rxq_head = '0;
    logic              rxq_empty = 1'b1;
    logic [PKT_W-1:0]  xl_pkt;
    logic [OFF_W-1:0]  xl_off;
    logic [AW-1:0]     xl_addr;
    logic              ram_en;
    logic              ram_we;
    logic [AW-2:0]     ram_addr;
    logic [1:0]        ram_be;
    logic [15:0]       ram_wdata;
    logic [15:0]       ram_rdata = '0;

    hbw_window #(.PKT_W(PKT_W), .OFF_W(OFF_W), .AW(AW)) u0 (.*);

    // allocator: scrambled packet number above the offset
    assign xl_addr = {xl_pkt ^ 5'h13, xl_off};

    logic [7:0] ram_arr [0:65535];
    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) begin
                if (ram_be[0]) ram_arr[{ram_addr, 1'b0}] <= ram_wdata[7:0];
                if (ram_be[1]) ram_arr[{ram_addr, 1'b1}] <= ram_wdata[15:8];
            end else begin
                ram_rdata <= {ram_arr[{ram_addr, 1'b1}], ram_arr[{ram_addr, 1'b0}]};
            end
        end
    end

    // reference model
    byte unsigned m_mem [0:65535];
    int  m_off = 0, m_rx = 0, m_auto = 0, m_pkt = 0, m_busy = 0;
    int  e_ready = 0, e_nv = 0, e_rd = 0;
    int  errors = 0, checks = 0;
    bit  chk_on = 0, done = 0;
    string tag = "R1";

    function automatic int phys(int pkt, int off);
        return ((pkt ^ 'h13) << 11) | off;
    endfunction

    task automatic chk(string t, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("R11", "dp_ready", int'(dp_ready), e_ready);
        chk("R9", "dp_nvalid", int'(dp_nvalid), e_nv);
        chk(tag, "dp_rdata", int'(dp_rdata), e_rd);
        chk(tag, "xl_off", int'(xl_off), m_off);
        chk(tag, "xl_pkt", int'(xl_pkt), (m_rx != 0) ? int'(rxq_head) : m_pkt);
    endtask

    task automatic step(input bit pw, input int pd, input bit kw, input int kd,
                        input bit rq, input bit we, input bit wd, input int wv);
        int a, tgt;
        bit acc;
        @(negedge clk);
        if (chk_on) compare();
        ptr_wr = pw; ptr_wdata = (OFF_W+2)'(pd);
        pkt_wr = kw; pkt_wdata = PKT_W'(kd);
        dp_req = rq; dp_we = we; dp_wide = wd; dp_wdata = 16'(wv);
        e_ready = 0; e_nv = 0; e_rd = 0;
        acc = rq && (m_busy == 0);
        if (acc) begin
            e_ready = 1;
            tgt = (m_rx != 0) ? int'(rxq_head) : m_pkt;
            if (m_rx != 0 && rxq_empty) begin
                e_nv = 1;
            end else begin
                a = phys(tgt, m_off);
                if (wd) begin
                    a = a & ~1;
                    if (we) begin
                        m_mem[a] = 8'(wv); m_mem[a+1] = 8'(wv >> 8);
                    end else begin
                        e_rd = (int'(m_mem[a+1]) << 8) | int'(m_mem[a]);
                    end
                end else begin
                    if (we) m_mem[a] = 8'(wv);
                    else e_rd = int'(m_mem[a]);
                end
            end
            if (m_auto != 0) m_off = (m_off + (wd ? 2 : 1)) % 2048;
        end
        m_busy = acc ? 1 : 0;
        if (pw) begin
            m_off = pd & 'h7FF; m_rx = (pd >> 11) & 1; m_auto = (pd >> 12) & 1;
        end
        if (kw) m_pkt = kd;
    endtask

    task automatic idle1();
        step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic ld_ptr(int off, int rx, int au);
        step(1, (au << 12) | (rx << 11) | off, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic ld_pkt(int p);
        step(0, 0, 1, p, 0, 0, 0, 0);
    endtask
    task automatic wr(bit wd, int v);
        step(0, 0, 0, 0, 1, 1, wd, v); idle1();
    endtask
    task automatic rd(bit wd);
        step(0, 0, 0, 0, 1, 0, wd, 0); idle1();
    endtask

    task automatic report();
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 65536; i++) begin
            ram_arr[i] = 8'h00;
            m_mem[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1;
        tag = "R1"; idle1(); idle1();
        tag = "R2"; ld_ptr(12'h123, 0, 0); idle1();
        tag = "R7"; ld_pkt(3); ld_ptr(16, 0, 0);
        wr(0, 'h5A); rd(0); wr(1, 'hBEEF); rd(1);
        ld_pkt(9); rd(1);
        tag = "R3"; ld_ptr(64, 0, 1);
        for (int i = 0; i < 4; i++) wr(0, 'h10 + i);
        ld_ptr(64, 0, 1);
        for (int i = 0; i < 4; i++) rd(0);
        tag = "R4"; ld_ptr(100, 0, 1);
        for (int i = 0; i < 3; i++) wr(1, 'hA100 + i * 'h0111);
        ld_ptr(100, 0, 1);
        for (int i = 0; i < 3; i++) rd(1);
        tag = "R12"; ld_ptr(100, 0, 1);
        for (int i = 0; i < 6; i++) rd(0);
        ld_ptr(200, 0, 0); wr(1, 'h1234); ld_ptr(201, 0, 0); wr(0, 'hC7);
        ld_ptr(200, 0, 0); rd(1);
        tag = "R5"; ld_ptr(2046, 0, 1); wr(1, 'h7788); idle1();
        ld_ptr(2047, 0, 1); rd(0); idle1();
        tag = "R6"; ld_ptr(64, 0, 0);
        for (int i = 0; i < 3; i++) rd(0);
        tag = "R2"; step(1, (1 << 12) | 300, 0, 0, 1, 0, 0, 0); idle1();
        tag = "R8"; ld_pkt(7); ld_ptr(40, 0, 1); wr(1, 'h4321); wr(0, 'h99);
        rxq_head = 5'd7; rxq_empty = 1'b0; ld_ptr(40, 1, 1); rd(1); rd(0);
        rxq_head = 5'd3; ld_ptr(16, 1, 0); rd(0);
        tag = "R9"; rxq_empty = 1'b1; ld_ptr(40, 1, 1); rd(1); rd(0);
        tag = "R10"; ld_ptr(40, 1, 0); wr(1, 'hDEAD);
        rxq_head = 5'd7; rxq_empty = 1'b0; idle1(); rd(1);
        tag = "R11"; ld_ptr(40, 1, 1);
        step(0, 0, 0, 0, 1, 0, 1, 0); step(0, 0, 0, 0, 1, 0, 1, 0); idle1(); idle1();
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog run did not end actual=0 expected=1");
            report();
        end
    end
endmodule